// File: doc/BRIEF.md
# UART Receive Idle Time-out Detector

This block sits beside a UART receiver and measures how long the line has stayed quiet since the last character. It marks the end of a variable-length frame. A 16-bit down-counter is loaded from a programmable limit whenever a character arrives. It steps down once for every bit-period tick. When it runs out, a sticky time-out flag is raised, and software can use that flag as an end-of-frame event. The interrupt request is the flag qualified by an enable input. A limit of zero switches the whole mechanism off.

Control is held in a three-state machine. `ST_IDLE` means not counting: the block is waiting for a character or a restart. `ST_COUNT` means counting bit periods. `ST_EXPIRED` means the count has run out and the block is waiting for software to clear the flag. The transitions are as follows.
- The load transition goes from any state to `ST_COUNT` when a character or a restart arrives with a nonzero limit.
- The expire transition goes from `ST_COUNT` to `ST_EXPIRED` on the tick that takes the count from one to zero.
- The acknowledge transition goes from `ST_EXPIRED` to `ST_IDLE` on a clear.
- The disable transition goes from any state to `ST_IDLE` while the limit is zero.

Clearing the flag does not re-arm the counter. A separate restart command re-arms it without waiting for a character.

Top module: `uart_idle_timeout`

## Requirements
- R1: After reset, `timeout_flag` and `irq` are 0 and no counting takes place until a character or restart.
- R2: While `timeout_val` is 0, the flag is forced to 0 at the next edge and stays 0, and characters, restarts and ticks have no effect.
- R3: A `char_rcvd` pulse with a nonzero `timeout_val` of N loads the count. The flag becomes 1 on the clock edge that samples the N-th `bit_tick` after the load, and is visible the cycle after that tick.
- R4: The count changes only on cycles with `bit_tick` high. Cycles without a tick leave the remaining time unchanged.
- R5: Every `char_rcvd` while counting reloads the full value N, so the time-out needs N further ticks.
- R6: Once set, the flag stays 1 until `clear_flag`, even if new characters arrive.
- R7: `clear_flag` drops the flag at the next edge. After a clear in `ST_EXPIRED`, the flag does not rise again without a new character or restart.
- R8: A `restart_cnt` pulse with a nonzero value loads N and starts counting without any character.
- R9: After the expire transition, counting stops. Further ticks do not raise the flag a second time in the same idle period.
- R10: `irq` equals `timeout_flag` AND `irq_en` in every cycle.
- R11: A load in the same cycle as a tick takes priority, so the counter reloads and does not step down. An expiring tick in the same cycle as `clear_flag` leaves the flag set.
- R12: The limit is captured at load time. Changing `timeout_val` to another nonzero value during a count does not change that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per receive bit period |
| char_rcvd | input | 1 | One-cycle pulse when the receiver completes a character |
| restart_cnt | input | 1 | Reload the counter and start counting now |
| clear_flag | input | 1 | Clear the sticky time-out flag |
| timeout_val | input | 16 | Time-out limit in bit periods, 0 disables |
| irq_en | input | 1 | Interrupt enable |
| timeout_flag | output | 1 | Sticky time-out status |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the following cases, each of which exposes a specific design error:
- An off-by-one in the terminal count would flag one tick early or late. This is probed with limits of 1, a small N, and 65535.
- A missing reload on characters that arrive mid-count would expire early. The same check exposes a design that lets a tick win over a same-cycle load.
- A design that keeps counting after expiry, or that re-arms on a clear, would raise the flag again after software acknowledged it.
- A design that lets clear win over a same-cycle expiry would lose the event.
- A design that reads the live limit instead of the loaded one would move the deadline when software rewrites it.

// File: rtl/uit_pkg.sv
package uit_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COUNT    = 2'd1,
        ST_EXPIRED  = 2'd2
    } uit_state_e;
endpackage

// File: rtl/uit_counter.sv
module uit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] load_val,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec && remain != '0) begin
            remain <= remain - ONE;
        end
    end

    // Final bit period: the next tick takes the count to zero.
    assign at_last = (remain == ONE);
endmodule

// File: rtl/uit_fsm.sv
module uit_fsm
    import uit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       char_rcvd,
    input  logic       restart_cnt,
    input  logic       clear_flag,
    input  logic       val_zero,
    input  logic       cnt_last,
    output logic       load,
    output logic       dec,
    output logic       flag,
    output uit_state_e state
);
    uit_state_e state_nx;
    logic       expire;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (val_zero) begin
            state_nx = ST_IDLE;                // disable transition
        end else if (load) begin
            state_nx = ST_COUNT;               // load transition
        end else begin
            unique case (state)
                ST_IDLE:    state_nx = ST_IDLE;
                ST_COUNT:   if (expire) state_nx = ST_EXPIRED;   // expire transition
                ST_EXPIRED: if (clear_flag) state_nx = ST_IDLE;  // acknowledge transition
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    // Outputs toward the counter
    always_comb begin
        load   = !val_zero && (char_rcvd || restart_cnt);
        dec    = 1'b0;
        unique case (state)
            ST_COUNT:   dec = bit_tick && !load && !val_zero;
            ST_IDLE,
            ST_EXPIRED: dec = 1'b0;
            default:    dec = 1'b0;
        endcase
        expire = dec && cnt_last;
    end

    // Sticky status: setting wins over clearing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (val_zero) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (clear_flag) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/uit_irq_gate.sv
module uit_irq_gate (
    input  logic status,
    input  logic enable,
    output logic req
);
    assign req = status & enable;
endmodule

// File: rtl/uart_idle_timeout.sv
module uart_idle_timeout
    import uit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             char_rcvd,
    input  logic             restart_cnt,
    input  logic             clear_flag,
    input  logic [CNT_W-1:0] timeout_val,
    input  logic             irq_en,
    output logic             timeout_flag,
    output logic             irq
);
    logic       val_zero;
    logic       cnt_load;
    logic       cnt_dec;
    logic       cnt_last;
    uit_state_e fsm_state;

    assign val_zero = (timeout_val == '0);

    uit_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .dec      (cnt_dec),
        .load_val (timeout_val),
        .at_last  (cnt_last)
    );

    uit_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .char_rcvd   (char_rcvd),
        .restart_cnt (restart_cnt),
        .clear_flag  (clear_flag),
        .val_zero    (val_zero),
        .cnt_last    (cnt_last),
        .load        (cnt_load),
        .dec         (cnt_dec),
        .flag        (timeout_flag),
        .state       (fsm_state)
    );

    uit_irq_gate u_irq (
        .status (timeout_flag),
        .enable (irq_en),
        .req    (irq)
    );
endmodule

// File: rtl/uit_checker.sv
module uit_checker
    import uit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_tick,
    input logic             char_rcvd,
    input logic             restart_cnt,
    input logic             clear_flag,
    input logic [CNT_W-1:0] timeout_val,
    input logic             irq_en,
    input logic             timeout_flag,
    input logic             irq,
    input uit_state_e       st
);
    a_r2_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_val == '0) |=> (!timeout_flag && st == ST_IDLE));

    a_r3_char_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (char_rcvd && timeout_val != '0) |=> (st == ST_COUNT));

    a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> $past(bit_tick));

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !clear_flag && timeout_val != '0) |=> timeout_flag);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_flag && st != ST_COUNT) |=> !timeout_flag);

    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_cnt && timeout_val != '0) |=> (st == ST_COUNT));

    a_r9_stop_after: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EXPIRED && !char_rcvd && !restart_cnt) |=> (st != ST_COUNT));

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && timeout_flag));
endmodule

bind uart_idle_timeout uit_checker #(.CNT_W(CNT_W)) u_uit_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .char_rcvd    (char_rcvd),
    .restart_cnt  (restart_cnt),
    .clear_flag   (clear_flag),
    .timeout_val  (timeout_val),
    .irq_en       (irq_en),
    .timeout_flag (timeout_flag),
    .irq          (irq),
    .st           (fsm_state)
);

// File: tb/test_uart_idle_timeout.sv
module test_uart_idle_timeout;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        char_rcvd = 1'b0;
    logic        restart_cnt = 1'b0;
    logic        clear_flag = 1'b0;
    logic [15:0] timeout_val = 16'd0;
    logic        irq_en = 1'b0;
    logic        timeout_flag;
    logic        irq;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Behavioural reference model
    int m_left = 0;
    bit m_on = 1'b0;
    bit m_flag = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    uart_idle_timeout i_uart_idle_timeout (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .char_rcvd(char_rcvd),
        .restart_cnt(restart_cnt), .clear_flag(clear_flag), .timeout_val(timeout_val),
        .irq_en(irq_en), .timeout_flag(timeout_flag), .irq(irq)
    );

    always @(posedge clk) begin
        bit set_now;
        set_now = 1'b0;
        if (!rst_n) begin
            m_left = 0; m_on = 1'b0; m_flag = 1'b0;
        end else if (timeout_val == 16'd0) begin
            m_on = 1'b0; m_flag = 1'b0;
        end else begin
            if (char_rcvd || restart_cnt) begin
                m_left = int'(timeout_val); m_on = 1'b1;
            end else if (m_on && bit_tick) begin
                m_left = m_left - 1;
                if (m_left == 0) begin set_now = 1'b1; m_on = 1'b0; end
            end
            if (set_now) m_flag = 1'b1;
            else if (clear_flag) m_flag = 1'b0;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            checks++;
            if (timeout_flag !== m_flag || irq !== (m_flag && irq_en)) begin
                failures++;
                $display("FAIL %s model: flag=%0b irq=%0b expected flag=%0b irq=%0b",
                         cur_req, timeout_flag, irq, m_flag, m_flag && irq_en);
            end
        end
        if (cycles > 190000) begin
            failures++;
            $display("FAIL watchdog: cycles=%0d expected < 190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic cyc(input bit t, input bit c, input bit cl, input bit rs);
        @(negedge clk); #1;
        bit_tick = t; char_rcvd = c; clear_flag = cl; restart_cnt = rs;
        @(posedge clk); #1;
        bit_tick = 0; char_rcvd = 0; clear_flag = 0; restart_cnt = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
    endtask

    task automatic chk(input string req, input bit exp_flag, input bit exp_irq);
        checks++;
        if (timeout_flag !== exp_flag || irq !== exp_irq) begin
            failures++;
            $display("FAIL %s: flag=%0b irq=%0b expected flag=%0b irq=%0b",
                     req, timeout_flag, irq, exp_flag, exp_irq);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cur_req = "R1";
        chk("R1 reset", 0, 0);
        timeout_val = 16'd3;
        ticks(5);
        chk("R1 no count before char", 0, 0);

        cur_req = "R3";
        irq_en = 1'b1;
        timeout_val = 16'd5;
        cyc(0, 1, 0, 0);
        ticks(4);
        chk("R3 before Nth tick", 0, 0);
        ticks(1);
        chk("R3 at Nth tick", 1, 1);

        cur_req = "R9";
        ticks(10);
        chk("R9 held after expiry", 1, 1);
        cyc(0, 0, 1, 0);
        chk("R7 clear", 0, 0);
        ticks(12);
        chk("R9 no second rise", 0, 0);

        cur_req = "R4";
        cyc(0, 1, 0, 0);
        for (int i = 0; i < 4; i++) begin cyc(1, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); end
        chk("R4 idle cycles do not count", 0, 0);
        ticks(1);
        chk("R4 expiry after 5 ticks", 1, 1);
        cyc(0, 0, 1, 0);

        cur_req = "R5";
        cyc(0, 1, 0, 0);
        ticks(3);
        cyc(0, 1, 0, 0);
        ticks(4);
        chk("R5 reload extends", 0, 0);
        ticks(1);
        chk("R5 expiry after reload", 1, 1);

        cur_req = "R6";
        cyc(0, 1, 0, 0);
        ticks(2);
        chk("R6 sticky with new char", 1, 1);
        cur_req = "R7";
        cyc(0, 0, 1, 0);
        chk("R7 clear while counting", 0, 0);
        ticks(3);
        chk("R7 counting continues", 1, 1);
        cyc(0, 0, 1, 0);

        cur_req = "R8";
        cyc(0, 0, 0, 1);
        ticks(4);
        chk("R8 restart counting", 0, 0);
        ticks(1);
        chk("R8 restart expiry", 1, 1);

        cur_req = "R10";
        irq_en = 1'b0;
        #1 chk("R10 irq masked", 1, 0);
        irq_en = 1'b1;
        #1 chk("R10 irq enabled", 1, 1);
        cyc(0, 0, 1, 0);

        cur_req = "R11";
        timeout_val = 16'd3;
        cyc(0, 1, 0, 0);
        ticks(2);
        cyc(1, 1, 0, 0);
        ticks(2);
        chk("R11 load beats tick", 0, 0);
        ticks(1);
        chk("R11 expiry after reload", 1, 1);
        cyc(0, 0, 1, 0);
        timeout_val = 16'd2;
        cyc(0, 1, 0, 0);
        ticks(1);
        cyc(1, 0, 1, 0);
        chk("R11 set beats clear", 1, 1);
        cyc(0, 0, 1, 0);

        cur_req = "R12";
        timeout_val = 16'd4;
        cyc(0, 1, 0, 0);
        timeout_val = 16'd9;
        ticks(3);
        chk("R12 before captured limit", 0, 0);
        ticks(1);
        chk("R12 captured limit used", 1, 1);
        cyc(0, 0, 1, 0);

        cur_req = "R2";
        cyc(0, 1, 0, 0);
        ticks(8);
        timeout_val = 16'd0;
        ticks(1);
        chk("R2 zero clears flag", 0, 0);
        cyc(0, 1, 0, 0);
        cyc(0, 0, 0, 1);
        ticks(20);
        chk("R2 disabled", 0, 0);

        cur_req = "R3";
        timeout_val = 16'd1;
        cyc(0, 1, 0, 0);
        chk("R3 limit 1 before tick", 0, 0);
        ticks(1);
        chk("R3 limit 1", 1, 1);
        cyc(0, 0, 1, 0);
        timeout_val = 16'hFFFF;
        cyc(0, 1, 0, 0);
        ticks(65534);
        chk("R3 limit 65535 before", 0, 0);
        ticks(1);
        chk("R3 limit 65535", 1, 1);

        cyc(0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule